// File: doc/BRIEF.md
# Bus Cycle Termination and Fault Controller

This block sits beside a processor's bus interface and decides how each bus cycle ends. Three external inputs (transfer acknowledge, bus error and halt) pass through a synchroniser first. The block classifies the cycle on the first clock edge where the synchronised acknowledge or bus error is seen. The level of halt on that edge picks the variant. The possible outcomes are a normal completion, a completion followed by a halt between cycles, a bus-error exception, or a halt with three-stated buses followed by a retry of the identical cycle. The core uses the halt-between-cycles behaviour to single-step one bus cycle at a time.

The block keeps a fault window. The window is open from reset until the core reports that an instruction has started, and it opens again whenever a bus-error exception is raised. A bus error that ends as an exception while the window is open is a double fault. The block then parks in a halted state, and only the asynchronous reset or an external reset held together with halt releases it. A retried cycle is not an exception, so it never opens or consumes the window. Two reset helpers complete the block. One pulses a core reset when external reset and halt are held together long enough. The other stretches a software reset request into a fixed-length reset drive.

Top module: `bus_term_ctl`

## Requirements
- R1: When a cycle is in progress, an acknowledge with bus error and halt both low gives one `cyc_done_o` pulse. The controller then stays running (`bus_en_o`=1, `halted_o`=0). At most one of the pulse outputs is high in any clock.
- R2: If halt is high on or before the edge where the acknowledge is classified, and bus error is low, the block gives one `cyc_done_o` pulse and then halts (`halted_o`=1, `bus_en_o`=0, `fc_en_o`=0) until halt is released. Cycle starts and acknowledges that arrive while halted, or after release with no new cycle, have no effect.
- R3: A bus error with halt low ends the cycle. This holds whether the bus error comes alone or on the same edge as the acknowledge, and in that case no `cyc_done_o` is given. `bus_en_o` stays 0 while the bus error is held, and `fc_en_o` stays 1. When the bus error drops, one `exc_req_o` pulse is given with `exc_vec_o` = 0x000008.
- R4: A bus error together with halt halts the block with `bus_en_o`=0 and `fc_en_o`=0. When halt is released, one `retry_o` pulse is given and the same cycle is live again, with no new cycle start needed and no `exc_req_o`.
- R5: A retry is not counted as an exception. A re-run taken while the fault window is open still gives `retry_o` and no double fault.
- R6: A bus error that would end as an exception while the fault window is open is a double fault. The window is open after any reset and after any `exc_req_o`, and `instr_start_i` closes it. In a double fault `halted_o`=1, `bus_en_o`=0 and `fc_en_o`=0, and no exception is raised. This state ignores halt and bus error and holds until a reset.
- R7: External reset and halt high together for RST_HOLD (10) consecutive synchronised clocks give one `core_rst_o` pulse. That pulse clears a double fault and reopens the fault window. A shorter hold has no effect.
- R8: A `sw_reset_i` pulse drives `reset_drv_o` high for exactly SW_RST_CYCLES (124) clocks and leaves the halt and bus-enable state unchanged.
- R9: After the asynchronous reset, `bus_en_o`=1, `fc_en_o`=1, `halted_o`=0, `reset_drv_o`=0, and all pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_start_i | input | 1 | Core starts a bus cycle (one-clock pulse) |
| instr_start_i | input | 1 | Core begins executing an instruction; closes the fault window |
| dtack_i | input | 1 | Transfer acknowledge (asynchronous) |
| berr_i | input | 1 | Bus error (asynchronous) |
| halt_i | input | 1 | Halt request (asynchronous) |
| sys_reset_i | input | 1 | External reset request (asynchronous) |
| sw_reset_i | input | 1 | Software reset request (one-clock pulse) |
| cyc_done_o | output | 1 | Cycle completed |
| retry_o | output | 1 | Re-run of the held cycle begins |
| exc_req_o | output | 1 | Bus-error exception request |
| exc_vec_o | output | ADDR_W | Handler vector address, valid with exc_req_o |
| bus_en_o | output | 1 | Address and data drivers enabled |
| fc_en_o | output | 1 | Function-code drivers enabled |
| halted_o | output | 1 | Controller halted |
| reset_drv_o | output | 1 | Drive the system reset line |
| core_rst_o | output | 1 | Reset pulse for the core |

## Verification
The termination logic is tried with several orderings: acknowledge alone, halt before the acknowledge, and halt on the same edge. It is also tried with bus error alone, bus error on the same edge as the acknowledge, and bus error together with halt. Each ordering must produce a different pulse, or a different pattern on the bus and function-code enables, so a wrong priority shows up as a wrong event. The fault window is exercised in three ways: a re-run inside an open window, a bus error right after an exception, and a bus error right after a core reset. This separates retries from exceptions and reset-time faults from ordinary ones. The reset helpers are checked with a hold that is too short and one that is long enough, and by counting the reset-drive length.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CYC,
    ST_BERR,
    ST_RERUN,
    ST_HALT,
    ST_DFAULT
  } term_state_e;

  localparam int unsigned BERR_VEC_ADDR = 8;
endpackage

// File: rtl/bus_term_sync.sv
module bus_term_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= '0;
    else         pipe_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '0;
      else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/bus_term_fsm.sv
module bus_term_fsm
  import bus_term_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_s_i,
  input  logic berr_s_i,
  input  logic halt_s_i,
  input  logic cyc_start_i,
  input  logic instr_start_i,
  input  logic core_rst_i,
  output logic cyc_done_o,
  output logic retry_o,
  output logic exc_req_o,
  output logic bus_en_o,
  output logic fc_en_o,
  output logic halted_o,
  output logic dfault_o
);
  term_state_e st_q, st_d;
  logic win_q, win_d;
  logic done_q, done_d, retry_q, retry_d, exc_q, exc_d;

  always_comb begin
    st_d    = st_q;
    win_d   = instr_start_i ? 1'b0 : win_q;
    done_d  = 1'b0;
    retry_d = 1'b0;
    exc_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (halt_s_i)         st_d = ST_HALT;
        else if (cyc_start_i) st_d = ST_CYC;
      end
      ST_CYC: begin
        if (berr_s_i) begin
          if (halt_s_i)   st_d = ST_RERUN;
          else if (win_q) st_d = ST_DFAULT;
          else            st_d = ST_BERR;
        end else if (ack_s_i) begin
          done_d = 1'b1;
          st_d   = halt_s_i ? ST_HALT : ST_IDLE;
        end
      end
      ST_BERR: begin
        if (!berr_s_i) begin
          exc_d = 1'b1;
          win_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_RERUN: begin
        if (!halt_s_i) begin
          retry_d = 1'b1;
          st_d    = ST_CYC;
        end
      end
      ST_HALT: begin
        if (!halt_s_i) st_d = ST_IDLE;
      end
      ST_DFAULT: st_d = ST_DFAULT;
      default:   st_d = ST_IDLE;
    endcase
    if (core_rst_i) begin
      st_d    = ST_IDLE;
      win_d   = 1'b1;
      done_d  = 1'b0;
      retry_d = 1'b0;
      exc_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      win_q   <= 1'b1;
      done_q  <= 1'b0;
      retry_q <= 1'b0;
      exc_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      win_q   <= win_d;
      done_q  <= done_d;
      retry_q <= retry_d;
      exc_q   <= exc_d;
    end
  end

  assign cyc_done_o = done_q;
  assign retry_o    = retry_q;
  assign exc_req_o  = exc_q;
  assign bus_en_o   = (st_q == ST_IDLE) || (st_q == ST_CYC);
  assign halted_o   = (st_q == ST_RERUN) || (st_q == ST_HALT) || (st_q == ST_DFAULT);
  assign fc_en_o    = !halted_o;
  assign dfault_o   = (st_q == ST_DFAULT);
endmodule

// File: rtl/bus_term_rst.sv
module bus_term_rst #(
  parameter int unsigned RST_HOLD      = 10,
  parameter int unsigned SW_RST_CYCLES = 124
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_s_i,
  input  logic halt_s_i,
  input  logic sw_reset_i,
  output logic core_rst_o,
  output logic reset_drv_o
);
  localparam int unsigned HW = $clog2(RST_HOLD + 1);
  localparam int unsigned SW = $clog2(SW_RST_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_MAX  = HW'(RST_HOLD);
  localparam logic [HW-1:0] HOLD_LAST = HW'(RST_HOLD - 1);
  localparam logic [SW-1:0] SW_LOAD   = SW'(SW_RST_CYCLES);

  logic [HW-1:0] hold_q;
  logic [SW-1:0] sw_cnt_q;
  logic          core_rst_q;
  logic          both_w;

  assign both_w = sys_rst_s_i && halt_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      core_rst_q <= 1'b0;
    end else begin
      core_rst_q <= both_w && (hold_q == HOLD_LAST);
      if (!both_w)              hold_q <= '0;
      else if (hold_q != HOLD_MAX) hold_q <= hold_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              sw_cnt_q <= '0;
    else if (sw_cnt_q != '0)  sw_cnt_q <= sw_cnt_q - 1'b1;
    else if (sw_reset_i)      sw_cnt_q <= SW_LOAD;
  end

  assign core_rst_o  = core_rst_q;
  assign reset_drv_o = (sw_cnt_q != '0);
endmodule

// File: rtl/bus_term_ctl.sv
module bus_term_ctl
  import bus_term_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned RST_HOLD      = 10,
  parameter int unsigned SW_RST_CYCLES = 124,
  parameter int unsigned ADDR_W        = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_start_i,
  input  logic              instr_start_i,
  input  logic              dtack_i,
  input  logic              berr_i,
  input  logic              halt_i,
  input  logic              sys_reset_i,
  input  logic              sw_reset_i,
  output logic              cyc_done_o,
  output logic              retry_o,
  output logic              exc_req_o,
  output logic [ADDR_W-1:0] exc_vec_o,
  output logic              bus_en_o,
  output logic              fc_en_o,
  output logic              halted_o,
  output logic              reset_drv_o,
  output logic              core_rst_o
);
  localparam int unsigned NSYNC = 4;

  logic [NSYNC-1:0] raw_w, syn_w;
  logic             core_rst_w, dfault_w;

  assign raw_w = {sys_reset_i, halt_i, berr_i, dtack_i};

  bus_term_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_w),
    .q_o   (syn_w)
  );

  bus_term_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ack_s_i      (syn_w[0]),
    .berr_s_i     (syn_w[1]),
    .halt_s_i     (syn_w[2]),
    .cyc_start_i  (cyc_start_i),
    .instr_start_i(instr_start_i),
    .core_rst_i   (core_rst_w),
    .cyc_done_o   (cyc_done_o),
    .retry_o      (retry_o),
    .exc_req_o    (exc_req_o),
    .bus_en_o     (bus_en_o),
    .fc_en_o      (fc_en_o),
    .halted_o     (halted_o),
    .dfault_o     (dfault_w)
  );

  bus_term_rst #(.RST_HOLD(RST_HOLD), .SW_RST_CYCLES(SW_RST_CYCLES)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sys_rst_s_i(syn_w[3]),
    .halt_s_i   (syn_w[2]),
    .sw_reset_i (sw_reset_i),
    .core_rst_o (core_rst_w),
    .reset_drv_o(reset_drv_o)
  );

  assign core_rst_o = core_rst_w;
  assign exc_vec_o  = exc_req_o ? ADDR_W'(BERR_VEC_ADDR) : '0;
endmodule

// File: rtl/bus_term_ctl_chk.sv
module bus_term_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sw_reset_i,
  input logic cyc_done_o,
  input logic retry_o,
  input logic exc_req_o,
  input logic bus_en_o,
  input logic fc_en_o,
  input logic halted_o,
  input logic reset_drv_o,
  input logic core_rst_o,
  input logic dfault_w
);
  a_r1_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cyc_done_o, retry_o, exc_req_o}));

  a_r2_halt_tristate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> (!bus_en_o && !fc_en_o));

  a_r3_exc_after_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> (!$past(bus_en_o) && fc_en_o));

  a_r4_retry_from_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> ($past(halted_o) && bus_en_o));

  a_r6_dfault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dfault_w && !core_rst_o) |=> dfault_w);

  a_r7_core_rst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |=> !core_rst_o);

  a_r8_drv_from_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_drv_o) |-> $past(sw_reset_i));
endmodule

bind bus_term_ctl bus_term_ctl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sw_reset_i (sw_reset_i),
  .cyc_done_o (cyc_done_o),
  .retry_o    (retry_o),
  .exc_req_o  (exc_req_o),
  .bus_en_o   (bus_en_o),
  .fc_en_o    (fc_en_o),
  .halted_o   (halted_o),
  .reset_drv_o(reset_drv_o),
  .core_rst_o (core_rst_o),
  .dfault_w   (dfault_w)
);

// File: tb/bus_term_ctl_tb_top.sv
`timescale 1ns/1ps
module bus_term_ctl_tb_top;
  localparam int ADDR_W = 24;
  localparam logic [3:0] EV_DONE = 4'b0001;
  localparam logic [3:0] EV_RETRY = 4'b0010;
  localparam logic [3:0] EV_EXC = 4'b0100;
  localparam logic [3:0] EV_CRST = 4'b1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 0, instr_start = 0, dtack = 0, berr = 0, halt = 0;
  logic sys_reset = 0, sw_reset = 0;
  logic cyc_done_o, retry_o, exc_req_o, bus_en_o, fc_en_o, halted_o;
  logic reset_drv_o, core_rst_o;
  logic [ADDR_W-1:0] exc_vec_o;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 0;
  logic [3:0] exp_q[$];
  string req_q[$];

  always #2 clk = ~clk;

  bus_term_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cyc_start_i(cyc_start), .instr_start_i(instr_start),
    .dtack_i(dtack), .berr_i(berr), .halt_i(halt), .sys_reset_i(sys_reset),
    .sw_reset_i(sw_reset), .cyc_done_o(cyc_done_o), .retry_o(retry_o),
    .exc_req_o(exc_req_o), .exc_vec_o(exc_vec_o), .bus_en_o(bus_en_o),
    .fc_en_o(fc_en_o), .halted_o(halted_o), .reset_drv_o(reset_drv_o),
    .core_rst_o(core_rst_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ev(input logic [3:0] code, input string req);
    exp_q.push_back(code);
    req_q.push_back(req);
  endtask

  task automatic drain(input string req);
    tick(4);
    check(exp_q.size() == 0, req, "expected events still pending", exp_q.size(), 0);
    exp_q.delete();
    req_q.delete();
  endtask

  task automatic start_cyc();
    cyc_start = 1; tick(1); cyc_start = 0;
  endtask

  task automatic instr_go();
    instr_start = 1; tick(1); instr_start = 0;
  endtask

  task automatic expect_lvl(input string req, input logic bus, input logic fc,
                            input logic hlt);
    check(bus_en_o == bus, req, "bus_en_o", bus_en_o, bus);
    check(fc_en_o == fc, req, "fc_en_o", fc_en_o, fc);
    check(halted_o == hlt, req, "halted_o", halted_o, hlt);
  endtask

  // Monitor: every pulse on an event output must match the queue head
  always @(negedge clk) begin
    logic [3:0] ev;
    ev = {core_rst_o, exc_req_o, retry_o, cyc_done_o};
    if (rst_n && ev != 4'b0) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected event", ev, 0);
      end else begin
        logic [3:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(ev == e, r, "event code", ev, e);
      end
      if (exc_req_o) check(exc_vec_o == 24'h000008, "R3", "exc_vec_o", exc_vec_o, 8);
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run hung actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R9 reset state
    expect_lvl("R9", 1, 1, 0);
    check(reset_drv_o == 0, "R9", "reset_drv_o", reset_drv_o, 0);
    check({cyc_done_o, retry_o, exc_req_o, core_rst_o} == 0, "R9", "pulses", 0, 0);
    instr_go();

    // R1 normal termination
    start_cyc(); tick(2);
    expect_ev(EV_DONE, "R1");
    dtack = 1; tick(5); dtack = 0;
    drain("R1");
    expect_lvl("R1", 1, 1, 0);

    // R3 bus error alone
    start_cyc(); tick(1);
    berr = 1; tick(6);
    expect_lvl("R3", 0, 1, 0);
    expect_ev(EV_EXC, "R3");
    berr = 0; tick(4);
    drain("R3");
    expect_lvl("R3", 1, 1, 0);
    instr_go();

    // R3 bus error on the same edge as acknowledge: no done
    start_cyc(); tick(1);
    expect_ev(EV_EXC, "R3");
    dtack = 1; berr = 1; tick(6);
    check(bus_en_o == 0, "R3", "bus_en_o with ack+berr", bus_en_o, 0);
    dtack = 0; berr = 0;
    drain("R3");
    instr_go();

    // R2 halt before acknowledge, then starts/acks ignored
    start_cyc();
    halt = 1; tick(4);
    check(bus_en_o == 1, "R2", "bus_en_o before ack", bus_en_o, 1);
    expect_ev(EV_DONE, "R2");
    dtack = 1; tick(5); dtack = 0;
    drain("R2");
    expect_lvl("R2", 0, 0, 1);
    start_cyc(); tick(3);
    expect_lvl("R2", 0, 0, 1);
    halt = 0; tick(5);
    expect_lvl("R2", 1, 1, 0);
    dtack = 1; tick(5); dtack = 0;
    drain("R2");

    // R2 halt on the same edge as acknowledge
    start_cyc(); tick(1);
    expect_ev(EV_DONE, "R2");
    dtack = 1; halt = 1; tick(5); dtack = 0;
    drain("R2");
    expect_lvl("R2", 0, 0, 1);
    halt = 0; tick(5);
    expect_lvl("R2", 1, 1, 0);

    // R4 re-run: berr with halt, retry on release, same cycle live
    start_cyc(); tick(1);
    berr = 1; halt = 1; tick(5);
    expect_lvl("R4", 0, 0, 1);
    berr = 0; tick(3);
    expect_ev(EV_RETRY, "R4");
    halt = 0; tick(5);
    drain("R4");
    expect_lvl("R4", 1, 1, 0);
    expect_ev(EV_DONE, "R4");
    dtack = 1; tick(5); dtack = 0;
    drain("R4");

    // R5 re-run inside an open window (after an exception)
    start_cyc(); tick(1);
    expect_ev(EV_EXC, "R5");
    berr = 1; tick(4); berr = 0;
    drain("R5");
    start_cyc(); tick(1);
    berr = 1; halt = 1; tick(5); berr = 0; tick(3);
    expect_ev(EV_RETRY, "R5");
    halt = 0; tick(5);
    drain("R5");
    expect_lvl("R5", 1, 1, 0);
    check(1, "R5", "retry not a double fault", 0, 0);

    // R6 bus error while window still open -> double fault
    berr = 1; tick(5); berr = 0; tick(5);
    drain("R6");
    expect_lvl("R6", 0, 0, 1);
    halt = 1; tick(4); halt = 0; tick(4);
    berr = 1; tick(3); berr = 0; tick(4);
    drain("R6");
    expect_lvl("R6", 0, 0, 1);

    // R7 short hold has no effect, full hold clears the fault
    sys_reset = 1; halt = 1; tick(5);
    sys_reset = 0; halt = 0; tick(5);
    drain("R7");
    expect_lvl("R7", 0, 0, 1);
    expect_ev(EV_CRST, "R7");
    sys_reset = 1; halt = 1; tick(13);
    sys_reset = 0; halt = 0; tick(6);
    drain("R7");
    expect_lvl("R7", 1, 1, 0);

    // R6 window reopened by core reset: first bus error is a double fault
    start_cyc(); tick(1);
    berr = 1; tick(4); berr = 0; tick(5);
    drain("R6");
    expect_lvl("R6", 0, 0, 1);

    // R9 async reset clears it
    rst_n = 0; tick(2); rst_n = 1; tick(1);
    expect_lvl("R9", 1, 1, 0);
    instr_go();

    // R8 software reset drive length
    begin
      int len = 0;
      sw_reset = 1; tick(1); sw_reset = 0;
      for (int i = 0; i < 300; i++) begin
        if (reset_drv_o) len++;
        tick(1);
      end
      check(len == 124, "R8", "reset_drv_o length", len, 124);
      expect_lvl("R8", 1, 1, 0);
    end
    drain("R8");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule